// File: doc/BRIEF.md
# INTx Interrupt Status and Mask Controller

This block gathers the four legacy level-sensitive INTx lines of a PCI host bridge, together with eight bus-error events, into one cascaded interrupt output for a parent interrupt controller. It holds one 32-bit control word that the configuration port reads and writes.

Inside the word, a pending flag for each INTx line, a set of line enables, a set of error-event enables and seven bits of plain storage share the register. The pending flags are cleared by writing ones. A read-modify-write that writes zeros to the pending field therefore leaves interrupts that have not been serviced untouched. The output is high when any pending line is enabled, or when any sampled error event is enabled.

The configuration port addresses 32-bit words. The control word lives at word index 0x13, which is byte offset 0x4C. Writes are qualified per byte lane. Reads are combinational from the current state.

Top module: `intx_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, the control word reads 0x00000000 and irq_o is low.
- R2: Only word index 0x13 is decoded. Any other index reads 0 and ignores writes.
- R3: Pending bit 28+i (INTA is bit 28, INTD is bit 31) sets at a clock edge where intx_i[i] is high. It stays set after the line drops.
- R4: A write to word 0x13 with cfg_be_i[3] set clears each pending bit whose data bit 31:28 is 1. A 0 in a pending position leaves that bit as it is.
- R5: A clear takes precedence at its own edge. If the line is still high, the pending bit sets again at the following edge.
- R6: Bits 25:22 enable INTD..INTA. irq_o is high when a line's pending bit and its enable are both set. A masked pending bit still reads back.
- R7: Error enables map err_i[0..7] to bits 16, 17, 18, 19, 20, 21, 26, 27. err_i is sampled by one register stage, and irq_o follows a sampled event whose enable is set.
- R8: Bits 14:8 are plain read/write storage. Bits 15 and 7:0 read zero.
- R9: Byte lane k (bits 8k+7:8k) is written only when cfg_be_i[k] is set.
- R10: Writing 0xF0000000 with byte enables 4'b1100 clears all four pending bits and masks all four lines in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe, one cycle per write |
| cfg_addr_i | input | 6 | Configuration word index |
| cfg_be_i | input | 4 | Byte-lane write enables |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| intx_i | input | 4 | INTA..INTD levels, bit 0 is INTA |
| err_i | input | 8 | Bus-error events |
| irq_o | output | 1 | Cascaded interrupt to the parent |

## Verification
The hardest case to reach is a clear that arrives while its line is still asserted. The expected trace is one cycle with the pending bit low, followed by a re-set. The bench holds a line high, issues the write-one-to-clear, and reads back in the gap cycle and again one edge later. The bench also sweeps every pending pattern against every enable pattern, and every error event against every single error enable.

// File: rtl/intx_irq_pkg.sv
package intx_irq_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned NUM_ERR   = 8;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned ADDR_W    = 6;
  localparam logic [ADDR_W-1:0] REG_WORD = 6'h13;

  localparam int unsigned STS_LSB   = 28;
  localparam int unsigned EN_LSB    = 22;
  localparam int unsigned PRIO_LSB  = 8;
  localparam int unsigned PRIO_W    = 7;

  localparam logic [DATA_W-1:0] RW_MASK = 32'h0FFF_7F00;
endpackage

// File: rtl/intx_cfg_decode.sv
module intx_cfg_decode
  import intx_irq_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  output logic              hit_o,
  output logic [LANES-1:0]  lane_we_o
);
  assign hit_o     = (addr_i == REG_WORD);
  assign lane_we_o = {LANES{we_i & hit_o}} & be_i;
endmodule

// File: rtl/intx_line_status.sv
module intx_line_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic q;
    // clear wins; a held line re-sets on the next edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[i]) q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
    end
    assign sts_o[i] = q;
  end
endmodule

// File: rtl/intx_ctrl_regs.sv
module intx_ctrl_regs
  import intx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rw_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (lane_we_i[k]) q <= wdata_i[8*k +: 8] & RW_MASK[8*k +: 8];
    end
    assign rw_o[8*k +: 8] = q;
  end
endmodule

// File: rtl/intx_irq_merge.sv
module intx_irq_merge
  import intx_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] sts_i,
  input  logic [NUM_LINES-1:0] intx_en_i,
  input  logic [NUM_ERR-1:0]   err_i,
  input  logic [NUM_ERR-1:0]   err_en_i,
  output logic                 irq_o
);
  logic [NUM_ERR-1:0] err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= err_i;
  end
  assign irq_o = (|(sts_i & intx_en_i)) | (|(err_q & err_en_i));
endmodule

// File: rtl/intx_irq_ctrl.sv
module intx_irq_ctrl
  import intx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [5:0]        cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic [3:0]        intx_i,
  input  logic [7:0]        err_i,
  output logic              irq_o
);
  logic                 hit;
  logic [LANES-1:0]     lane_we;
  logic [DATA_W-1:0]    rw_q;
  logic [NUM_LINES-1:0] sts_q;
  logic [NUM_LINES-1:0] clr;
  logic [NUM_LINES-1:0] intx_en;
  logic [NUM_ERR-1:0]   err_en;

  intx_cfg_decode u_dec (
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .be_i(cfg_be_i),
    .hit_o(hit), .lane_we_o(lane_we)
  );

  intx_ctrl_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_we_i(lane_we),
    .wdata_i(cfg_wdata_i), .rw_o(rw_q)
  );

  assign clr = lane_we[LANES-1] ? cfg_wdata_i[STS_LSB +: NUM_LINES] : '0;

  intx_line_status #(.N(NUM_LINES)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(intx_i), .clr_i(clr), .sts_o(sts_q)
  );

  assign intx_en = rw_q[EN_LSB +: NUM_LINES];
  assign err_en  = {rw_q[27], rw_q[26], rw_q[21:16]};

  intx_irq_merge u_merge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sts_i(sts_q), .intx_en_i(intx_en),
    .err_i(err_i), .err_en_i(err_en), .irq_o(irq_o)
  );

  assign cfg_rdata_o = hit ? ({sts_q, {STS_LSB{1'b0}}} | rw_q) : '0;
endmodule

// File: rtl/intx_irq_ctrl_chk.sv
module intx_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [5:0] cfg_addr_i,
  input logic [3:0] cfg_be_i,
  input logic [3:0] clr_data_i,
  input logic [3:0] intx_i,
  input logic [3:0] sts_i,
  input logic [3:0] intx_en_i,
  input logic [7:0] err_en_i,
  input logic       irq_o
);
  logic       wr_top;
  logic [3:0] clr_now;
  assign wr_top  = cfg_we_i && (cfg_addr_i == 6'h13) && cfg_be_i[3];
  assign clr_now = wr_top ? clr_data_i : 4'b0;

  a_r4_clear_takes_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_top |=> ((sts_i & $past(clr_data_i)) == 4'b0));

  a_r3_line_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & $past(intx_i & ~clr_now)) == $past(intx_i & ~clr_now)));

  a_r3_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sts_i & ~clr_now) & ~sts_i) == 4'b0));

  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_i & ~$past(sts_i) & ~$past(intx_i)) == 4'b0));

  a_r6_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intx_en_i == 4'b0 && err_en_i == 8'b0) |-> !irq_o);

  a_r6_enabled_pending_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sts_i & intx_en_i)) |-> irq_o);
endmodule

bind intx_irq_ctrl intx_irq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
  .cfg_be_i(cfg_be_i), .clr_data_i(cfg_wdata_i[31:28]), .intx_i(intx_i),
  .sts_i(sts_q), .intx_en_i(intx_en), .err_en_i(err_en), .irq_o(irq_o)
);

// File: tb/intx_irq_ctrl_bench.sv
module intx_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] W = 6'h13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [5:0] addr = W;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] intx = '0;
  logic [7:0] err = '0;
  logic irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_irq_ctrl u_intx_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .intx_i(intx), .err_i(err), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); addr = a; be = b; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = W; be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata; addr = W;
  endtask

  function automatic logic [31:0] bitpos(input int idx);
    int p[8] = '{16, 17, 18, 19, 20, 21, 26, 27};
    return 32'h1 << p[idx];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    intx = 4'hF;
    repeat (2) @(negedge clk);
    rd(W, d); chk("R1 reg in reset", d, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    intx = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(W, d); chk("R1 reg after reset", d, 32'h0);

    // R8 / R9: lane-by-lane writes of all ones
    wr(W, 4'b0010, 32'hFFFF_FFFF);
    rd(W, d); chk("R8 R9 lane1 only", d, 32'h0000_7F00);
    wr(W, 4'b0001, 32'hFFFF_FFFF);
    rd(W, d); chk("R8 low byte reads zero", d, 32'h0000_7F00);
    wr(W, 4'b0100, 32'hFFFF_FFFF);
    rd(W, d); chk("R9 lane2", d, 32'h00FF_7F00);
    wr(W, 4'b1000, 32'h0FFF_FFFF);
    rd(W, d); chk("R9 lane3", d, 32'h0FFF_7F00);

    // R2: other words ignore writes and read zero
    wr(6'h12, 4'b1111, 32'h0000_0000);
    wr(6'h00, 4'b1111, 32'h0000_0000);
    rd(W, d); chk("R2 other word write ignored", d, 32'h0FFF_7F00);
    rd(6'h14, d); chk("R2 other word reads zero", d, 32'h0);

    // R10: one halfword write clears and masks
    @(negedge clk); intx = 4'hF; @(negedge clk); intx = 4'h0;
    rd(W, d); chk("R3 all pending", d[31:28], 32'hF);
    wr(W, 4'b1100, 32'hF000_0000);
    rd(W, d); chk("R10 clear and mask", d, 32'h0000_7F00);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    wr(W, 4'b0010, 32'h0);

    // R3 R6: every pending pattern against every enable pattern
    for (int en = 0; en < 16; en++) begin
      for (int pat = 0; pat < 16; pat++) begin
        logic [31:0] e;
        wr(W, 4'b1100, {4'hF, 2'b00, en[3:0], 22'b0});
        intx = pat[3:0]; @(negedge clk); intx = 4'h0;
        e = {pat[3:0], 2'b00, en[3:0], 22'b0};
        rd(W, d); chk("R3 R6 status and enable readback", d, e);
        chk("R6 irq", {31'b0, irq}, {31'b0, |(pat[3:0] & en[3:0])});
        @(negedge clk);
        rd(W, d); chk("R3 sticky after line drop", d, e);
      end
    end

    // R4: zero in pending field leaves status, one clears just that bit
    wr(W, 4'b1100, 32'hF000_0000);
    intx = 4'b0101; @(negedge clk); intx = 4'h0;
    wr(W, 4'b1111, 32'h0000_0000);
    rd(W, d); chk("R4 write zero keeps pending", d, 32'h5000_0000);
    wr(W, 4'b1111, 32'h4000_0000);
    rd(W, d); chk("R4 write one clears one bit", d, 32'h1000_0000);
    wr(W, 4'b0111, 32'hF000_0000);
    rd(W, d); chk("R4 lane3 disabled no clear", d, 32'h1000_0000);

    // R5: clear while line held
    wr(W, 4'b1100, 32'hF000_0000);
    @(negedge clk); intx = 4'b0010;
    @(negedge clk);
    wr(W, 4'b1000, 32'h2000_0000);
    rd(W, d); chk("R5 clear wins at its edge", d, 32'h0);
    @(negedge clk);
    rd(W, d); chk("R5 re-set next edge", d, 32'h2000_0000);
    intx = 4'h0;
    wr(W, 4'b1100, 32'hF000_0000);

    // R7: each error event against each single enable
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        wr(W, 4'b1100, 32'hF000_0000 | bitpos(j));
        err = 8'h1 << i;
        @(negedge clk);
        chk("R7 error routed", {31'b0, irq}, {31'b0, i == j});
        err = 8'h0;
        @(negedge clk);
        chk("R7 error follows sample", {31'b0, irq}, 32'h0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule